// File: doc/BRIEF.md
# Serial Flash Command Receiver

This block is the serial-facing receiver of a flash memory model that has two page buffers. While the select line is held low, it takes serial bits on each rising edge of the serial clock. The first 8 bits form a command byte. The next 24 bits form an address word. The block decodes the command byte into an operation and a choice of buffer. It pulls a page number and a byte offset out of the address word. For the program-through-buffer operation, every complete byte that follows the address is written into the selected 264-byte buffer.

When the select line returns high, a complete and recognised command is passed to the page sequencer as a single-cycle launch pulse with its decoded fields. The sequencer reads the buffer contents through a registered read port. The select, clock and data lines are asynchronous to the system clock. They pass through two-flop synchronisers before any edge is detected.

Top module: `flash_cmd_rx`

## Requirements
- R1: After reset, `launch` is low and no buffer write takes place until a command is shifted in.
- R2: Bits are taken on rising `ser_clk` edges while `ser_sel_n` is low, most significant bit first. The command byte comes first. It is followed by a 24-bit address word whose bits 23..19 are ignored, bits 18..9 are the page number and bits 8..0 are the byte offset.
- R3: Command bytes decode as follows, given as launch_op / launch_buf. 82h → 0/0 and 85h → 0/1 (program through buffer). 53h → 1/0 and 55h → 1/1 (page into buffer). 60h → 2/0 and 61h → 2/1 (compare). 58h → 3/0 and 59h → 3/1 (rewrite).
- R4: When `ser_sel_n` rises after a complete, recognised command, `launch` is high for exactly one system clock, and `launch_op`, `launch_buf` and `launch_page` carry the decoded values. `launch_ofs` carries the start offset for op 0 and zero for every other op.
- R5: For op 0, each complete data byte after the address is written to the selected buffer. The first byte goes to the start offset and each later byte to the next offset.
- R6: The write offset advances from 263 back to 0.
- R7: A byte offset field of 264 or more is reduced by 264 before it is used, both as the write start and as `launch_ofs`.
- R8: If the select line rises before all 32 header bits have arrived, no launch is issued. Trailing data bits that do not form a whole byte are not written.
- R9: A command byte outside the eight listed values produces no launch and no buffer write.
- R10: A command that begins while `seq_busy` is high produces no launch and no buffer write.
- R11: A program command leaves the buffer it did not select unchanged.
- R12: Data bytes that follow the address of ops 1, 2 or 3 are not written to either buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_din | input | 1 | Serial data in |
| seq_busy | input | 1 | Sequencer busy; a command started while high is dropped |
| launch | output | 1 | One-cycle command launch pulse |
| launch_op | output | 2 | Decoded operation (0 program, 1 page-to-buffer, 2 compare, 3 rewrite) |
| launch_buf | output | 1 | Buffer select of the launched command |
| launch_page | output | 10 | Page number of the launched command |
| launch_ofs | output | 9 | Start offset for op 0, zero otherwise |
| rd_buf | input | 1 | Buffer selected for sequencer read |
| rd_addr | input | 9 | Read offset |
| rd_data | output | 8 | Read byte, one cycle after the address |

## Verification
On every cycle, the assertions check the following. The launch pulse lasts a single cycle and follows a rise of the select line. The reported offset stays below 264. Every buffer write belongs to a program command. The write pointer steps by one and returns from 263 to 0. A select fall while busy leaves the receiver inactive. Some behaviour only the bench scenarios can show. Bit order and field positions, the full opcode table, offset reduction, and dropped incomplete, unknown or busy commands are all checked through launch contents and buffer read-back against a reference model. The same read-back shows that the unselected buffer and the non-program data bytes leave the memories untouched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_XFER = 2'd1,
        OP_CMP  = 2'd2,
        OP_REWR = 2'd3
    } op_e;

    typedef struct packed {
        logic valid;
        op_e  op;
        logic buf_sel;
    } dec_t;

    function automatic dec_t decode_cmd(input logic [7:0] code);
        dec_t r;
        r = '{valid: 1'b1, op: OP_PROG, buf_sel: 1'b0};
        case (code)
            8'h82: r = '{valid: 1'b1, op: OP_PROG, buf_sel: 1'b0};
            8'h85: r = '{valid: 1'b1, op: OP_PROG, buf_sel: 1'b1};
            8'h53: r = '{valid: 1'b1, op: OP_XFER, buf_sel: 1'b0};
            8'h55: r = '{valid: 1'b1, op: OP_XFER, buf_sel: 1'b1};
            8'h60: r = '{valid: 1'b1, op: OP_CMP,  buf_sel: 1'b0};
            8'h61: r = '{valid: 1'b1, op: OP_CMP,  buf_sel: 1'b1};
            8'h58: r = '{valid: 1'b1, op: OP_REWR, buf_sel: 1'b0};
            8'h59: r = '{valid: 1'b1, op: OP_REWR, buf_sel: 1'b1};
            default: r = '{valid: 1'b0, op: OP_PROG, buf_sel: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            hold_q <= meta_q;
        end
    end

    assign sync_out = hold_q;
endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (waddr < DEPTH_V)) begin
            mem[waddr] <= wdata;
        end
        if (raddr < DEPTH_V) begin
            rdata_q <= mem[raddr];
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

    // R6: a write never lands beyond the last buffer byte
    p_waddr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < DEPTH_V))
        else $error("buffer write address out of range");
endmodule

// File: rtl/flash_cmd_parse.sv
module flash_cmd_parse
    import flash_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_W     = 10,
    parameter int OFS_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              seq_busy,
    output logic              launch,
    output logic [1:0]        launch_op,
    output logic              launch_buf,
    output logic [PAGE_W-1:0] launch_page,
    output logic [OFS_W-1:0]  launch_ofs,
    output logic              wr_en,
    output logic              wr_buf,
    output logic [OFS_W-1:0]  wr_addr,
    output logic [7:0]        wr_data
);
    localparam int CMD_BITS = 8;
    localparam int HDR_BITS = CMD_BITS + 24;
    localparam int FLD_BITS = PAGE_W + OFS_W;
    localparam int CW       = $clog2(HDR_BITS + 1);
    localparam logic [CW-1:0]    C_CMD_LAST = CW'(CMD_BITS - 1);
    localparam logic [CW-1:0]    C_HDR_LAST = CW'(HDR_BITS - 1);
    localparam logic [CW-1:0]    C_HDR      = CW'(HDR_BITS);
    localparam logic [OFS_W-1:0] DEPTH_V    = OFS_W'(PAGE_BYTES);
    localparam logic [OFS_W-1:0] LAST_V     = OFS_W'(PAGE_BYTES - 1);

    typedef struct packed {
        logic               active;
        logic               sel_prev;
        logic               sclk_prev;
        logic [CW-1:0]      cnt;
        logic [CMD_BITS-2:0] cmd_sr;
        dec_t               dec;
        logic [FLD_BITS-2:0] fld_sr;
        logic [PAGE_W-1:0]  page;
        logic [OFS_W-1:0]   start;
        logic [OFS_W-1:0]   ptr;
        logic [2:0]         bitn;
        logic [6:0]         dat_sr;
        logic               launch;
        logic               wr_en;
        logic [OFS_W-1:0]   wr_addr;
        logic [7:0]         wr_data;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [OFS_W-1:0] fold_ofs(input logic [OFS_W-1:0] o);
        return (o >= DEPTH_V) ? (o - DEPTH_V) : o;
    endfunction

    logic                sel_fall, sel_rise, sclk_rise;
    logic [FLD_BITS-1:0] fld_full;
    logic [OFS_W-1:0]    ofs_fold;

    always_comb begin
        sel_fall  = st_q.sel_prev && !sel_n_s;
        sel_rise  = !st_q.sel_prev && sel_n_s;
        sclk_rise = sclk_s && !st_q.sclk_prev;
        fld_full  = {st_q.fld_sr, din_s};
        ofs_fold  = fold_ofs(fld_full[OFS_W-1:0]);

        st_d           = st_q;
        st_d.sel_prev  = sel_n_s;
        st_d.sclk_prev = sclk_s;
        st_d.launch    = 1'b0;
        st_d.wr_en     = 1'b0;

        if (sel_fall) begin
            st_d.active    = !seq_busy;
            st_d.cnt       = '0;
            st_d.bitn      = '0;
            st_d.dec.valid = 1'b0;
        end else if (sel_rise) begin
            st_d.launch = st_q.active && (st_q.cnt == C_HDR) && st_q.dec.valid;
            st_d.active = 1'b0;
        end else if (!sel_n_s && st_q.active && sclk_rise) begin
            if (st_q.cnt != C_HDR) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt < C_CMD_LAST) begin
                    st_d.cmd_sr = {st_q.cmd_sr[CMD_BITS-3:0], din_s};
                end else if (st_q.cnt == C_CMD_LAST) begin
                    st_d.dec = decode_cmd({st_q.cmd_sr, din_s});
                end else begin
                    st_d.fld_sr = {st_q.fld_sr[FLD_BITS-3:0], din_s};
                    if (st_q.cnt == C_HDR_LAST) begin
                        st_d.page  = fld_full[FLD_BITS-1:OFS_W];
                        st_d.start = ofs_fold;
                        st_d.ptr   = ofs_fold;
                    end
                end
            end else if (st_q.dec.valid && (st_q.dec.op == OP_PROG)) begin
                st_d.bitn   = st_q.bitn + 1'b1;
                st_d.dat_sr = {st_q.dat_sr[5:0], din_s};
                if (st_q.bitn == 3'd7) begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_addr = st_q.ptr;
                    st_d.wr_data = {st_q.dat_sr, din_s};
                    st_d.ptr     = (st_q.ptr == LAST_V) ? '0 : st_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sel_prev  <= 1'b1;
            st_q.dec.op    <= OP_PROG;
        end else begin
            st_q <= st_d;
        end
    end

    assign launch      = st_q.launch;
    assign launch_op   = st_q.dec.op;
    assign launch_buf  = st_q.dec.buf_sel;
    assign launch_page = st_q.page;
    assign launch_ofs  = (st_q.dec.op == OP_PROG) ? st_q.start : '0;
    assign wr_en       = st_q.wr_en;
    assign wr_buf      = st_q.dec.buf_sel;
    assign wr_addr     = st_q.wr_addr;
    assign wr_data     = st_q.wr_data;

    // R4: launch is a single-cycle pulse
    p_launch_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch) else $error("launch longer than one cycle");

    // R4: launch only follows a rise of the select line
    p_launch_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> st_q.sel_prev) else $error("launch while select low");

    // R7: reported start offset lies inside the buffer
    p_ofs_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (launch_ofs < DEPTH_V)) else $error("offset not reduced");

    // R9 / R12: buffer writes only for a recognised program command
    p_write_prog_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.dec.valid && (st_q.dec.op == OP_PROG)))
        else $error("write without program command");

    // R6: pointer wraps from the last byte to zero
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == LAST_V)) |-> (st_q.ptr == '0))
        else $error("pointer failed to wrap");

    // R5: pointer steps by one after an ordinary write
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != LAST_V)) |-> (st_q.ptr == wr_addr + 1'b1))
        else $error("pointer did not advance");

    // R10: a command begun while busy leaves the receiver inactive
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel_prev && !sel_n_s && seq_busy) |=> !st_q.active)
        else $error("busy command accepted");
endmodule

// File: rtl/flash_cmd_rx.sv
module flash_cmd_rx #(
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_W     = 10,
    parameter int OFS_W      = 9,
    parameter int NUM_BUF    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              seq_busy,
    output logic              launch,
    output logic [1:0]        launch_op,
    output logic              launch_buf,
    output logic [PAGE_W-1:0] launch_page,
    output logic [OFS_W-1:0]  launch_ofs,
    input  logic              rd_buf,
    input  logic [OFS_W-1:0]  rd_addr,
    output logic [7:0]        rd_data
);
    logic [2:0]       pins_s;
    logic             wr_en;
    logic             wr_buf;
    logic [OFS_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             rd_buf_q;
    logic [7:0]       buf_rdata [NUM_BUF];

    flash_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_sel_n, ser_clk, ser_din}),
        .sync_out (pins_s)
    );

    flash_cmd_parse #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_W     (PAGE_W),
        .OFS_W      (OFS_W)
    ) i_parse (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_s     (pins_s[2]),
        .sclk_s      (pins_s[1]),
        .din_s       (pins_s[0]),
        .seq_busy    (seq_busy),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_buf  (launch_buf),
        .launch_page (launch_page),
        .launch_ofs  (launch_ofs),
        .wr_en       (wr_en),
        .wr_buf      (wr_buf),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        flash_page_buf #(.DEPTH(PAGE_BYTES), .AW(OFS_W), .DW(8)) i_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_buf == 1'(g))),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr),
            .rdata (buf_rdata[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_buf_q <= 1'b0;
        else        rd_buf_q <= rd_buf;
    end

    assign rd_data = buf_rdata[rd_buf_q];
endmodule

// File: tb/test_flash_cmd_rx.sv
module test_flash_cmd_rx;
    localparam int NB = 264;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_sel_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       seq_busy = 1'b0;
    logic       launch;
    logic [1:0] launch_op;
    logic       launch_buf;
    logic [9:0] launch_page;
    logic [8:0] launch_ofs;
    logic       rd_buf = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    flash_cmd_rx i_flash_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .seq_busy(seq_busy), .launch(launch),
        .launch_op(launch_op), .launch_buf(launch_buf), .launch_page(launch_page),
        .launch_ofs(launch_ofs), .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct {
        logic [1:0] op;
        logic       b;
        logic [9:0] page;
        logic [8:0] ofs;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] model [2][NB];
    int checks = 0;
    int errors = 0;
    int seen   = 0;
    int want   = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: pops expected launches and compares them
    always @(negedge clk) begin
        if (rst_n && launch) begin
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, $sformatf("R9 unexpected launch op=%0d buf=%0d page=%0d: actual 1 expected 0",
                      launch_op, launch_buf, launch_page));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(launch_op == e.op && launch_buf == e.b && launch_page == e.page && launch_ofs == e.ofs,
                      $sformatf("%s launch fields actual op=%0d buf=%0d page=%0d ofs=%0d expected op=%0d buf=%0d page=%0d ofs=%0d",
                      e.req, launch_op, launch_buf, launch_page, launch_ofs, e.op, e.b, e.page, e.ofs));
            end
        end
    end

    task automatic shift_bit(input logic b);
        ser_din = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    task automatic send_raw(input logic [7:0] opc, input logic [23:0] adr, input int hdr_bits,
                            input int nbytes, input logic [7:0] seed, input int extra_bits);
        logic [31:0] hdr;
        hdr = {opc, adr};
        @(negedge clk);
        ser_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < hdr_bits; i++) shift_bit(hdr[31 - i]);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] d;
            d = dbyte(seed, k);
            for (int j = 7; j >= 0; j--) shift_bit(d[j]);
        end
        for (int j = 0; j < extra_bits; j++) shift_bit(1'b1);
        repeat (4) @(negedge clk);
        ser_sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_prog(input logic b, input logic [9:0] page, input logic [8:0] ofs_raw,
                           input int n, input logic [7:0] seed, input int extra, input string req);
        exp_t e;
        int p;
        p = int'(ofs_raw) % NB;
        e = '{op: 2'd0, b: b, page: page, ofs: 9'(p), req: req};
        exp_q.push_back(e);
        want++;
        for (int i = 0; i < n; i++) begin
            model[b][p] = dbyte(seed, i);
            p = (p + 1) % NB;
        end
        send_raw(b ? 8'h85 : 8'h82, {5'b10110, page, ofs_raw}, 32, n, seed, extra);
    endtask

    task automatic do_other(input logic [7:0] opc, input logic [1:0] op, input logic b,
                            input logic [9:0] page, input string req);
        exp_t e;
        e = '{op: op, b: b, page: page, ofs: 9'd0, req: req};
        exp_q.push_back(e);
        want++;
        send_raw(opc, {5'b11111, page, 9'h1A5}, 32, 3, 8'h3C, 0);
    endtask

    task automatic check_count(input string req);
        check(seen == want && exp_q.size() == 0,
              $sformatf("%s launch count actual %0d expected %0d", req, seen, want));
    endtask

    task automatic check_bufs(input string req);
        int bad = 0;
        int fa = -1;
        logic [7:0] fv = '0;
        for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < NB; a++) begin
                @(negedge clk);
                rd_buf = 1'(b);
                rd_addr = 9'(a);
                @(negedge clk);
                if (rd_data !== model[b][a]) begin
                    if (bad == 0) begin fa = b * 1000 + a; fv = rd_data; end
                    bad++;
                end
            end
        end
        check(bad == 0, $sformatf("%s buffer contents: %0d mismatches, first buf*1000+addr=%0d actual %0h expected %0h",
              req, bad, fa, fv, (fa < 0) ? 8'h0 : model[fa / 1000][fa % 1000]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(launch == 1'b0, $sformatf("R1 reset launch actual %0b expected 0", launch));
        check(seen == 0, $sformatf("R1 no launch after reset actual %0d expected 0", seen));

        // fill both buffers fully (R2, R3, R4, R5, R11)
        do_prog(1'b0, 10'd5, 9'd0, NB, 8'h11, 0, "R5");
        check_count("R4");
        do_prog(1'b1, 10'd1023, 9'd0, NB, 8'h80, 0, "R2");
        check_count("R2");
        check_bufs("R5");

        // wrap at the end of the buffer (R6), buffer 1 untouched (R11)
        do_prog(1'b0, 10'd7, 9'd260, 6, 8'hE0, 0, "R6");
        check_count("R6");
        check_bufs("R11");

        // offset folded modulo 264 (R7)
        do_prog(1'b1, 10'h155, 9'd300, 3, 8'h42, 0, "R7");
        check_count("R7");
        check_bufs("R7");

        // other opcodes, data after address ignored (R3, R12)
        do_other(8'h53, 2'd1, 1'b0, 10'h2AA, "R3");
        do_other(8'h55, 2'd1, 1'b1, 10'h001, "R3");
        do_other(8'h60, 2'd2, 1'b0, 10'h200, "R3");
        do_other(8'h61, 2'd2, 1'b1, 10'h0F0, "R3");
        do_other(8'h58, 2'd3, 1'b0, 10'h3FF, "R3");
        do_other(8'h59, 2'd3, 1'b1, 10'h10A, "R3");
        check_count("R3");
        check_bufs("R12");

        // incomplete header, then trailing partial byte (R8)
        send_raw(8'h82, {5'b0, 10'd9, 9'd20}, 20, 0, 8'h00, 0);
        check_count("R8");
        do_prog(1'b0, 10'd9, 9'd10, 1, 8'h5A, 3, "R8");
        check_count("R8");
        check_bufs("R8");

        // unknown opcode (R9)
        send_raw(8'h83, {5'b0, 10'd3, 9'd0}, 32, 4, 8'h99, 0);
        check_count("R9");
        check_bufs("R9");

        // busy at command start (R10)
        @(negedge clk);
        seq_busy = 1'b1;
        send_raw(8'h85, {5'b0, 10'd4, 9'd0}, 32, 4, 8'h77, 0);
        seq_busy = 1'b0;
        check_count("R10");
        check_bufs("R10");

        // normal operation resumes after busy (R4)
        do_other(8'h61, 2'd2, 1'b1, 10'h123, "R4");
        check_count("R4");
        check(launch == 1'b0, $sformatf("R4 launch idle actual %0b expected 0", launch));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule